// File: doc/BRIEF.md
# Packed Monochrome Bitmap Blitter

This block copies a rectangular window of 1-bit pixels into an 8-bit-per-pixel framebuffer. A command gives the window origin, its size and the pitch of the source bitmap in bits. The pixel bits arrive as a stream of bytes over a valid/ready handshake. Each bit becomes one framebuffer write: a set bit writes the brightness input as it is at that moment, and a clear bit writes zero.

Before any data moves, the command is checked against the matrix dimensions and against its own pitch. A bad command produces only an error response. A good command walks the window in row-major order and drives one write-port beat per pixel. It then signals completion with a single-cycle done pulse. Any unused bits left in the final byte are discarded, so each command starts on a fresh byte.

Top module: `mono_blit`

## Requirements
- R1: A command with x >= MAT_W or x + width > MAT_W is rejected with an error.
- R2: A command with y >= MAT_H or y + height > MAT_H is rejected with an error.
- R3: A command whose pitch is smaller than its width is rejected with an error.
- R4: A rejected command causes no framebuffer write and no byte handshake. done_valid with done_err = 1 appears in the cycle right after the command is accepted, and the block then returns to idle.
- R5: Source bits are consumed from bit 0 toward bit 7 of each byte. A new byte is requested only after all 8 bits of the current byte have been used. Rows do not realign to byte boundaries: bit k of the stream is bit k mod 8 of byte k div 8.
- R6: A set bit writes the brightness input value, and a clear bit writes 0.
- R7: The window is traversed row by row from y to y + height − 1, and left to right from x to x + width − 1 within each row. Each pixel (px, py) is written at address px + py·MAT_W.
- R8: After the width pixels of each row, a further pitch − width stream bits are consumed and produce no write.
- R9: After the last bit of the window, done_valid pulses for one cycle with done_err = 0. Exactly ceil(height·pitch/8) bytes have then been taken; the rest of the last byte is dropped.
- R10: A valid command with height = 0 or pitch = 0 completes with done_err = 0 in the cycle after acceptance, and takes no bytes.
- R11: cmd_ready is high only while idle, and never together with a write, a byte request or done. After reset the block is idle with no write, byte request or done asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_valid | input | 1 | command present |
| cmd_ready | output | 1 | block idle, command accepted on valid |
| cmd_x | input | CW | window left column |
| cmd_y | input | CW | window top row |
| cmd_w | input | CW | window width in pixels |
| cmd_h | input | CW | window height in rows |
| cmd_pitch | input | CW | source bits per row |
| brightness | input | PW | value written for set bits |
| byte_valid | input | 1 | source byte present |
| byte_data | input | 8 | packed source bits, bit 0 first |
| byte_ready | output | 1 | block takes a byte this cycle |
| fb_we | output | 1 | framebuffer write strobe |
| fb_addr | output | AW | framebuffer write address |
| fb_data | output | PW | framebuffer write data |
| done_valid | output | 1 | one-cycle completion pulse |
| done_err | output | 1 | command was rejected |

## Verification
The bench builds the block with a 7 × 5 matrix and 5-bit command fields. The odd matrix width makes every address depend on the multiply by width rather than on a shift. The narrow fields let an x + width sum that passes the field width (x = 3, width = 31) exercise the wide comparison of the bounds check. Pitches up to width + 5 over heights up to 5 produce windows that cross byte boundaries mid-row, together with zero-width and zero-height cases.

// File: rtl/mono_blit_pkg.sv
package mono_blit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } blit_state_e;

endpackage

// File: rtl/mono_blit_check.sv
module mono_blit_check #(
    parameter int MAT_W = 7,
    parameter int MAT_H = 5,
    parameter int CW    = 5
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic [CW-1:0] pitch,
    output logic          bad
);
    localparam logic [CW:0] LIM_W = (CW+1)'(MAT_W);
    localparam logic [CW:0] LIM_H = (CW+1)'(MAT_H);

    logic [CW:0] x_end;
    logic [CW:0] y_end;
    logic        bad_x;
    logic        bad_y;
    logic        bad_p;

    always_comb begin
        x_end = {1'b0, x} + {1'b0, w};
        y_end = {1'b0, y} + {1'b0, h};
        bad_x = ({1'b0, x} >= LIM_W) || (x_end > LIM_W);   // R1
        bad_y = ({1'b0, y} >= LIM_H) || (y_end > LIM_H);   // R2
        bad_p = (pitch < w);                               // R3
        bad   = bad_x || bad_y || bad_p;
    end

endmodule

// File: rtl/mono_blit_unpack.sv
module mono_blit_unpack #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          flush,
    input  logic          take,
    input  logic          byte_valid,
    input  logic [BW-1:0] byte_data,
    output logic          byte_ready,
    output logic          bit_valid,
    output logic          bit_val
);
    localparam int IW = $clog2(BW);
    localparam logic [IW-1:0] LAST = IW'(BW - 1);

    typedef struct packed {
        logic          have;
        logic [IW-1:0] idx;
        logic [BW-1:0] word;
    } unpack_t;

    unpack_t cur_q, nxt_d;

    always_comb begin
        byte_ready = enable && !cur_q.have;
        bit_valid  = cur_q.have;
        bit_val    = cur_q.word[cur_q.idx];

        nxt_d = cur_q;
        if (flush) begin
            nxt_d.have = 1'b0;
        end else if (take && cur_q.have) begin
            nxt_d.idx = cur_q.idx + 1'b1;
            if (cur_q.idx == LAST) begin
                nxt_d.have = 1'b0;
            end
        end else if (byte_valid && byte_ready) begin
            nxt_d.word = byte_data;
            nxt_d.idx  = '0;
            nxt_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // a freshly loaded byte presents its bit 0 first
    assert_load_lsb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> (bit_valid && bit_val == $past(byte_data[0])));

    // the walker only consumes a bit that is present
    assert_take_has_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> bit_valid);

endmodule

// File: rtl/mono_blit.sv
module mono_blit
    import mono_blit_pkg::*;
#(
    parameter int MAT_W = 7,
    parameter int MAT_H = 5,
    parameter int CW    = 5,
    parameter int PW    = 8,
    parameter int AW    = $clog2(MAT_W * MAT_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [CW-1:0] cmd_x,
    input  logic [CW-1:0] cmd_y,
    input  logic [CW-1:0] cmd_w,
    input  logic [CW-1:0] cmd_h,
    input  logic [CW-1:0] cmd_pitch,
    input  logic [PW-1:0] brightness,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    output logic          byte_ready,
    output logic          fb_we,
    output logic [AW-1:0] fb_addr,
    output logic [PW-1:0] fb_data,
    output logic          done_valid,
    output logic          done_err
);
    localparam int FB_SIZE = MAT_W * MAT_H;
    localparam logic [AW-1:0] ROW_STEP = AW'(MAT_W);

    typedef struct packed {
        blit_state_e   st;
        logic [CW-1:0] x;
        logic [CW-1:0] w;
        logic [CW-1:0] pitch;
        logic [CW-1:0] col;
        logic [CW-1:0] rows_left;
        logic [AW-1:0] base;
        logic          err;
    } walk_t;

    walk_t cur_q, nxt_d;

    logic cmd_bad;
    logic unp_en;
    logic unp_flush;
    logic unp_take;
    logic bit_valid;
    logic bit_val;

    mono_blit_check #(
        .MAT_W (MAT_W),
        .MAT_H (MAT_H),
        .CW    (CW)
    ) u_check (
        .x     (cmd_x),
        .y     (cmd_y),
        .w     (cmd_w),
        .h     (cmd_h),
        .pitch (cmd_pitch),
        .bad   (cmd_bad)
    );

    mono_blit_unpack #(
        .BW (8)
    ) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (unp_en),
        .flush      (unp_flush),
        .take       (unp_take),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val)
    );

    always_comb begin
        nxt_d      = cur_q;
        cmd_ready  = 1'b0;
        unp_en     = 1'b0;
        unp_flush  = 1'b0;
        unp_take   = 1'b0;
        fb_we      = 1'b0;
        fb_addr    = cur_q.base + AW'(cur_q.x) + AW'(cur_q.col);
        fb_data    = bit_val ? brightness : '0;
        done_valid = 1'b0;
        done_err   = cur_q.err;

        unique case (cur_q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    nxt_d.x         = cmd_x;
                    nxt_d.w         = cmd_w;
                    nxt_d.pitch     = cmd_pitch;
                    nxt_d.col       = '0;
                    nxt_d.rows_left = cmd_h;
                    nxt_d.base      = AW'(cmd_y) * ROW_STEP;
                    nxt_d.err       = cmd_bad;
                    if (cmd_bad || cmd_h == '0 || cmd_pitch == '0) begin
                        nxt_d.st = ST_RESP;
                    end else begin
                        nxt_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                unp_en = 1'b1;
                if (bit_valid) begin
                    unp_take = 1'b1;
                    fb_we    = (cur_q.col < cur_q.w);
                    if (cur_q.col == cur_q.pitch - 1'b1) begin
                        nxt_d.col       = '0;
                        nxt_d.base      = cur_q.base + ROW_STEP;
                        nxt_d.rows_left = cur_q.rows_left - 1'b1;
                        if (cur_q.rows_left == CW'(1)) begin
                            unp_flush = 1'b1;
                            nxt_d.st  = ST_RESP;
                        end
                    end else begin
                        nxt_d.col = cur_q.col + 1'b1;
                    end
                end
            end
            ST_RESP: begin
                done_valid = 1'b1;
                nxt_d.st   = ST_IDLE;
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assert_reject_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_bad) |=> (done_valid && done_err));

    assert_reject_is_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_err) |-> (!fb_we && !byte_ready));

    assert_addr_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ({1'b0, fb_addr} < (AW+1)'(FB_SIZE)));

    assert_pixel_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (fb_data == '0 || fb_data == brightness));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && cmd_ready));

    assert_idle_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!fb_we && !byte_ready && !done_valid));

    assert_no_write_while_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> !fb_we);

endmodule

// File: tb/tb_mono_blit.sv
`timescale 1ns/1ps
module tb_mono_blit;
    localparam int MAT_W = 7;
    localparam int MAT_H = 5;
    localparam int CW    = 5;
    localparam int PW    = 8;
    localparam int AW    = $clog2(MAT_W * MAT_H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [CW-1:0] cmd_x = '0, cmd_y = '0, cmd_w = '0, cmd_h = '0, cmd_pitch = '0;
    logic [PW-1:0] brightness = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          byte_ready;
    logic          fb_we;
    logic [AW-1:0] fb_addr;
    logic [PW-1:0] fb_data;
    logic          done_valid;
    logic          done_err;

    int total = 0;
    int bad   = 0;

    logic [7:0] src [0:31];
    int         exp_addr [0:63];
    int         exp_data [0:63];

    always #2.5 clk = ~clk;

    mono_blit #(.MAT_W(MAT_W), .MAT_H(MAT_H), .CW(CW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_pitch(cmd_pitch),
        .brightness(brightness), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
        .done_valid(done_valid), .done_err(done_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit ref_bad(input int x, input int y, input int w, input int h, input int p);
        return (x >= MAT_W) || (x + w > MAT_W) || (y >= MAT_H) || (y + h > MAT_H) || (p < w);
    endfunction

    function automatic int ref_bit(input int k);
        return int'(src[k / 8][k % 8]);
    endfunction

    task automatic run_cmd(input int x, input int y, input int w, input int h, input int p,
                           input int br, input string tag);
        bit  is_bad;
        int  nexp;
        int  nbytes;
        int  wi;
        int  bi;
        int  lat;
        bit  fin;
        is_bad = ref_bad(x, y, w, h, p);
        nexp = 0;
        nbytes = 0;
        for (int i = 0; i < 32; i++) src[i] = 8'($urandom);
        if (!is_bad) begin
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < p; c++) begin
                    if (c < w) begin
                        exp_addr[nexp] = x + c + (y + r) * MAT_W;
                        exp_data[nexp] = ref_bit(r * p + c) != 0 ? br : 0;
                        nexp++;
                    end
                end
            end
            nbytes = (h * p + 7) / 8;
        end
        @(negedge clk);
        chk(cmd_ready == 1'b1, {"R11 idle before ", tag}, int'(cmd_ready), 1);
        cmd_x = CW'(x); cmd_y = CW'(y); cmd_w = CW'(w); cmd_h = CW'(h); cmd_pitch = CW'(p);
        brightness = PW'(br);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wi = 0; bi = 0; lat = 0; fin = 1'b0;
        while (!fin) begin
            if (fb_we) begin
                if (wi < nexp) begin
                    chk(int'(fb_addr) == exp_addr[wi], {"R7 address ", tag}, int'(fb_addr), exp_addr[wi]);
                    chk(int'(fb_data) == exp_data[wi], {"R5 R6 pixel value ", tag}, int'(fb_data), exp_data[wi]);
                end else begin
                    chk(1'b0, {"R8 extra write ", tag}, wi + 1, nexp);
                end
                wi++;
            end
            if (done_valid) begin
                chk(done_err == is_bad, {"R1 R2 R3 error flag ", tag}, int'(done_err), int'(is_bad));
                chk(wi == nexp, {"R4 R8 write count ", tag}, wi, nexp);
                chk(bi == nbytes, {"R9 bytes taken ", tag}, bi, nbytes);
                if (is_bad || h == 0 || p == 0)
                    chk(lat == 0, {"R4 R10 response latency ", tag}, lat, 0);
                fin = 1'b1;
            end else begin
                byte_valid = (bi < nbytes + 2) && ($urandom % 4 != 0);
                byte_data  = src[bi];
                if (byte_valid && byte_ready) bi++;
                @(negedge clk);
                lat++;
                if (lat > 2000) begin
                    chk(1'b0, {"R9 watchdog ", tag}, lat, 0);
                    fin = 1'b1;
                end
            end
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk(done_valid == 1'b0 && cmd_ready == 1'b1, {"R9 single done pulse ", tag},
            int'(done_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R11 reset cmd_ready", int'(cmd_ready), 1);
        chk(fb_we == 1'b0 && byte_ready == 1'b0, "R11 reset outputs", int'(fb_we), 0);
        chk(done_valid == 1'b0, "R11 reset done", int'(done_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cmd(0, 0, 7, 5, 7, 255, "full frame");
        run_cmd(1, 1, 5, 3, 8, 90, "pitch w+3 R8");
        run_cmd(2, 0, 3, 5, 3, 17, "odd pitch R5");
        run_cmd(6, 4, 1, 1, 1, 200, "corner pixel");
        run_cmd(0, 0, 0, 2, 3, 9, "zero width R8");
        run_cmd(3, 2, 2, 0, 4, 9, "zero height R10");
        run_cmd(6, 0, 2, 1, 2, 9, "x+w over R1");
        run_cmd(7, 0, 0, 1, 1, 9, "x at edge R1");
        run_cmd(3, 0, 31, 1, 31, 9, "wide sum R1");
        run_cmd(0, 5, 1, 0, 1, 9, "y at edge R2");
        run_cmd(0, 2, 1, 4, 1, 9, "y+h over R2");
        run_cmd(0, 0, 4, 2, 3, 9, "pitch short R3");
        run_cmd(0, 0, 3, 2, 3, 1, "after errors R4");

        for (int n = 0; n < 150; n++) begin
            int x, y, w, h, p;
            x = $urandom % 9;
            y = $urandom % 6;
            w = $urandom % 9;
            h = $urandom % 6;
            p = w + $urandom % 6;
            if ($urandom % 8 == 0 && w > 0) p = w - 1;
            run_cmd(x, y, w, h, p, 1 + $urandom % 255, "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule